// File: doc/BRIEF.md
# Power Switch Ramp Timer

This block models the power switch of one power domain whose turn-on and turn-off ramps take a programmable time. Two count registers hold the ramp lengths: one for powering the domain off and one for powering it on. They are written through a simple write port. When the switch control input changes, the timer loads the count that matches the new direction. It then counts reference-clock enables, and only when that count runs out does it move the domain status output to the new state.

The reference enable is a single-cycle strobe from a slow reference clock. At a 24 MHz reference, a count of 24 is one microsecond. The status output uses 1 for a domain that is off and 0 for a domain that is on. A power manager polls this output after it changes the control, so the status lags the control by the programmed ramp. If the control reverses partway through a ramp, the ramp restarts in the new direction from its full count.

Top module: `pwr_ramp_timer`

## Requirements
- R1: After reset, `dom_off` is 1 (domain off; 0 means on), no ramp is pending, and both count registers hold `RST_CNT` (24 by default).
- R2: A write with `cfg_addr == BASE_ADDR` sets the power-down count. A write with `cfg_addr == BASE_ADDR + 4` sets the power-up count. Writes to any other address change neither count.
- R3: When `sw_off` goes from 0 to 1, `dom_off` becomes 1 at the clock edge of the N-th counted `ref_tick`, where N is the power-down count.
- R4: When `sw_off` goes from 1 to 0, `dom_off` becomes 0 at the clock edge of the N-th counted `ref_tick`, where N is the power-up count.
- R5: A ramp advances only on clock edges where `ref_tick` is 1, and `dom_off` never changes on an edge without `ref_tick`.
- R6: If `sw_off` reverses before a ramp ends, the counter reloads with the full count for the new direction and `dom_off` keeps its old value.
- R7: A count of 0 takes effect like a count of 1: `dom_off` follows the control on the first counted `ref_tick` after the change.
- R8: A write to a count register does not alter a ramp already running. A write in the same cycle as a control change still loads the value the register held before the write.
- R9: On the clock edge where a control change is seen, `ref_tick` is not counted. The first counted tick is on a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Count register write strobe |
| cfg_addr | input | ADDR_W | Write address |
| cfg_wdata | input | CNT_W | Write data (ramp length in reference ticks) |
| sw_off | input | 1 | Switch control: 1 requests off, 0 requests on |
| ref_tick | input | 1 | One-cycle enable per reference clock period |
| dom_off | output | 1 | Domain status: 1 off, 0 on |

## Verification
The ramp is tried with the reference enable held high, with the enable withheld for long stretches, and with an irregular random enable. Comparing these separates ticks that are counted from clock cycles that are not. Directed ramps with distinct down and up counts, and writes to neighbouring addresses, show that each direction picks its own register. Counts of 0 and 1 pin down the shortest ramp. Reversals mid-ramp, writes during a ramp, and a write in the same cycle as a control change show whether the running count is reloaded or stays untouched. A long random run with toggling control and scattered writes is checked every clock against a behavioural model.

// File: rtl/pwrsw_pkg.sv
package pwrsw_pkg;

   // Which count register a ramp direction uses
   typedef enum logic {
      SLOT_DOWN = 1'b0,
      SLOT_UP   = 1'b1
   } slot_e;

   // Domain status encoding
   typedef enum logic {
      DOM_ON  = 1'b0,
      DOM_OFF = 1'b1
   } dom_e;

   localparam int unsigned SLOT_STRIDE = 4;
   localparam int unsigned NUM_SLOTS   = 2;

   function automatic slot_e slot_for(input logic want_off);
      return want_off ? SLOT_DOWN : SLOT_UP;
   endfunction

endpackage

// File: rtl/pwrsw_cnt_regs.sv
module pwrsw_cnt_regs
   import pwrsw_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE_ADDR = 'h48,
   parameter int unsigned RST_CNT   = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  down_cnt,
   output logic [CNT_W-1:0]  up_cnt
);

   logic [CNT_W-1:0] slot_q [NUM_SLOTS];

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + i * SLOT_STRIDE);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[i] <= CNT_W'(RST_CNT);
         end else if (wr_en && (wr_addr == SLOT_ADDR)) begin
            slot_q[i] <= wr_data;
         end
      end
   end

   assign down_cnt = slot_q[SLOT_DOWN];
   assign up_cnt   = slot_q[SLOT_UP];

endmodule

// File: rtl/pwrsw_req_track.sv
module pwrsw_req_track
   import pwrsw_pkg::*;
#(
   parameter bit RST_OFF = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_off,
   output logic load,
   output logic tgt_off
);

   logic tgt_q;

   // Any difference between the control and the last accepted target is a new request
   assign load    = (ctrl_off != tgt_q);
   assign tgt_off = tgt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q <= RST_OFF;
      end else begin
         tgt_q <= ctrl_off;
      end
   end

endmodule

// File: rtl/pwrsw_ramp_ctr.sv
module pwrsw_ramp_ctr #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             busy,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             last_w;

   // Zero and one both finish on the first counted tick
   assign last_w = (cnt_q <= CNT_W'(1));
   assign done   = busy_q & tick & ~load & last_w;
   assign busy   = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (load) begin
         cnt_q  <= load_val;
         busy_q <= 1'b1;
      end else if (busy_q && tick) begin
         if (last_w) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/pwr_ramp_timer.sv
module pwr_ramp_timer
   import pwrsw_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE_ADDR = 'h48,
   parameter int unsigned RST_CNT   = 24,
   parameter bit          RST_OFF   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CNT_W-1:0]  cfg_wdata,
   input  logic              sw_off,
   input  logic              ref_tick,
   output logic              dom_off
);

   localparam longint unsigned ADDR_SPAN = longint'(1) << ADDR_W;
   localparam longint unsigned CNT_SPAN  = longint'(1) << CNT_W;

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W must be at least 2");
   end
   if ((BASE_ADDR % SLOT_STRIDE) != 0) begin : g_bad_align
      $error("BASE_ADDR must be word aligned");
   end
   if ((longint'(BASE_ADDR) + SLOT_STRIDE) >= ADDR_SPAN) begin : g_bad_addr
      $error("BASE_ADDR + 4 must fit in ADDR_W bits");
   end
   if (longint'(RST_CNT) >= CNT_SPAN) begin : g_bad_rst
      $error("RST_CNT must fit in CNT_W bits");
   end

   logic [CNT_W-1:0] down_cnt_w;
   logic [CNT_W-1:0] up_cnt_w;
   logic [CNT_W-1:0] ld_val_w;
   logic             ld_w;
   logic             tgt_w;
   logic             busy_w;
   logic             done_w;
   logic             st_q;

   pwrsw_cnt_regs #(
      .CNT_W     (CNT_W),
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .RST_CNT   (RST_CNT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata),
      .down_cnt (down_cnt_w),
      .up_cnt   (up_cnt_w)
   );

   pwrsw_req_track #(
      .RST_OFF (RST_OFF)
   ) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_off (sw_off),
      .load     (ld_w),
      .tgt_off  (tgt_w)
   );

   // Direction of the new request picks the register; the value is the one held before any same-cycle write
   assign ld_val_w = (slot_for(sw_off) == SLOT_DOWN) ? down_cnt_w : up_cnt_w;

   pwrsw_ramp_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_w),
      .load_val (ld_val_w),
      .tick     (ref_tick),
      .busy     (busy_w),
      .done     (done_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= RST_OFF;
      end else if (done_w) begin
         st_q <= tgt_w;
      end
   end

   assign dom_off = st_q;

endmodule

// File: rtl/pwr_ramp_timer_chk.sv
module pwr_ramp_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic sw_off,
   input logic ref_tick,
   input logic dom_off,
   input logic ld,
   input logic busy,
   input logic tgt
);

   AST_STATUS_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_off != $past(dom_off)) |-> $past(ref_tick)); // R5

   AST_STATUS_TO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_off != $past(dom_off)) |-> (dom_off == $past(sw_off))); // R3

   AST_LOAD_HOLDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> $stable(dom_off)); // R6

   AST_IDLE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dom_off == tgt)); // R4

   AST_LOAD_STARTS_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> busy); // R7

   AST_LOAD_SKIPS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && ref_tick) |=> (dom_off == $past(dom_off))); // R9

endmodule

bind pwr_ramp_timer pwr_ramp_timer_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sw_off   (sw_off),
   .ref_tick (ref_tick),
   .dom_off  (dom_off),
   .ld       (ld_w),
   .busy     (busy_w),
   .tgt      (tgt_w)
);

// File: tb/sim_pwr_ramp_timer.sv
`timescale 1ns/1ps
module sim_pwr_ramp_timer;

   localparam int CNT_W  = 16;
   localparam int ADDR_W = 8;
   localparam int BASE   = 'h48;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [CNT_W-1:0]  cfg_wdata = '0;
   logic              sw_off = 1'b1;
   logic              ref_tick = 1'b0;
   logic              dom_off;

   int    n_chk = 0;
   int    n_fail = 0;
   int    cyc = 0;
   bit    fin = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   int m_dn, m_up, m_rem;
   bit m_tgt, m_busy, m_st;

   always #5 clk = ~clk;

   pwr_ramp_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .sw_off(sw_off), .ref_tick(ref_tick), .dom_off(dom_off)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dn = 24; m_up = 24; m_rem = 0; m_tgt = 1; m_busy = 0; m_st = 1;
      end else begin
         if (sw_off != m_tgt) begin
            m_tgt  = sw_off;
            m_rem  = sw_off ? m_dn : m_up;
            m_busy = 1;
         end else if (m_busy && ref_tick) begin
            if (m_rem <= 1) begin
               m_st = m_tgt; m_busy = 0;
            end else begin
               m_rem = m_rem - 1;
            end
         end
         if (cfg_we && cfg_addr == ADDR_W'(BASE))     m_dn = int'(cfg_wdata);
         if (cfg_we && cfg_addr == ADDR_W'(BASE + 4)) m_up = int'(cfg_wdata);
      end
   end

   // compare against the model on every clock
   always @(negedge clk) begin
      if (rst_n && !fin) begin
         n_chk++;
         if (dom_off !== m_st) begin
            n_fail++;
            $display("FAIL %s model compare: dom_off=%0b expected=%0b at cycle %0d", cur_req, dom_off, m_st, cyc);
         end
      end
   end

   task automatic finish_run();
      fin = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !fin) begin
         n_chk++; n_fail++;
         $display("FAIL R5 watchdog: cycles=%0d expected below 150000", cyc);
         finish_run();
      end
   end

   task automatic check(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = ADDR_W'(addr); cfg_wdata = CNT_W'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // change control with a steady enable; return negedges until status follows
   task automatic measure(input bit tgt, input int exp_k, input string req);
      int k = 0;
      cur_req = req;
      @(negedge clk);
      sw_off = tgt; ref_tick = 1'b1;
      for (int j = 0; j < 2000; j++) begin
         @(negedge clk);
         k++;
         if (dom_off == tgt) break;
      end
      check(req, k, exp_k, "edges until status follows");
   endtask

   initial begin
      int k;
      repeat (3) @(negedge clk);
      check("R1", int'(dom_off), 1, "dom_off during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(dom_off), 1, "dom_off after reset");
      measure(1'b0, 25, "R1");               // default up count 24

      wr(BASE, 5); wr(BASE + 4, 3);
      wr(BASE + 8, 40); wr(BASE + 1, 40); wr(BASE + 5, 40);
      measure(1'b1, 6, "R3");
      measure(1'b0, 4, "R4");
      measure(1'b1, 6, "R2");
      measure(1'b0, 4, "R2");

      wr(BASE, 0);
      measure(1'b1, 2, "R7");
      wr(BASE + 4, 1);
      measure(1'b0, 2, "R7");

      // R5: no enable, no progress
      cur_req = "R5";
      wr(BASE, 4);
      @(negedge clk); sw_off = 1'b1; ref_tick = 1'b0;
      repeat (30) @(negedge clk);
      check("R5", int'(dom_off), 0, "status with enable withheld");
      ref_tick = 1'b1; k = 0;
      for (int j = 0; j < 100; j++) begin
         @(negedge clk); k++;
         if (dom_off == 1'b1) break;
      end
      check("R5", k, 4, "ticks after enable resumes");

      // R6: reversal mid-ramp
      cur_req = "R6";
      wr(BASE, 6); wr(BASE + 4, 10);
      @(negedge clk); sw_off = 1'b0; ref_tick = 1'b1;
      repeat (4) @(negedge clk);
      sw_off = 1'b1;
      repeat (5) @(negedge clk);
      check("R6", int'(dom_off), 1, "status kept across reversal");
      measure(1'b0, 11, "R6");

      // R8: write during a running ramp
      cur_req = "R8";
      wr(BASE, 7); wr(BASE + 4, 8);
      @(negedge clk); sw_off = 1'b1; ref_tick = 1'b1; k = 0;
      for (int j = 0; j < 100; j++) begin
         @(negedge clk); k++;
         if (k == 3) begin cfg_we = 1'b1; cfg_addr = ADDR_W'(BASE); cfg_wdata = 2; end
         if (k == 4) cfg_we = 1'b0;
         if (dom_off == 1'b1) break;
      end
      cfg_we = 1'b0;
      check("R8", k, 8, "ramp length with write mid-ramp");
      // write in the same cycle as the change uses the old up count 8
      @(negedge clk);
      sw_off = 1'b0; cfg_we = 1'b1; cfg_addr = ADDR_W'(BASE + 4); cfg_wdata = 1; k = 0;
      for (int j = 0; j < 100; j++) begin
         @(negedge clk); k++; cfg_we = 1'b0;
         if (dom_off == 1'b0) break;
      end
      check("R8", k, 9, "ramp length with write on change cycle");

      // R9: tick on the change edge is not counted
      wr(BASE, 3);
      measure(1'b1, 4, "R9");
      wr(BASE + 4, 2);
      measure(1'b0, 3, "R9");

      // irregular enables, toggles and writes against the model
      cur_req = "R6";
      for (int j = 0; j < 4000; j++) begin
         @(negedge clk);
         ref_tick = ($urandom % 3) != 0;
         if ($urandom % 23 == 0) sw_off = ~sw_off;
         if ($urandom % 37 == 0) begin
            int sel = $urandom % 3;
            cfg_we = 1'b1;
            cfg_addr = ADDR_W'((sel == 0) ? BASE : (sel == 1) ? BASE + 4 : BASE + 2);
            cfg_wdata = CNT_W'($urandom % 12);
         end else begin
            cfg_we = 1'b0;
         end
      end
      @(negedge clk); cfg_we = 1'b0;
      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule